// File: doc/BRIEF.md
# Per-Class Vote Tally and Argmax

This block turns the flat output vector of a hardware logic network's last layer into a class decision. The vector is cut into equal, contiguous groups, one group per class. Every bit in a group is one vote for that class, and all votes carry the same weight. The block counts the set bits of each group to form that class's score. It then reports the index of the class with the highest score, together with all of the scores.

A sample enters with `in_valid` high. The population counts are registered in a first stage. The argmax comparison is registered in a second stage. The result therefore appears two clock cycles later, flagged by `out_valid`. A new sample may be offered on every cycle. When several classes share the top score, the class with the smallest index wins. Between results the outputs keep the last decision.

Top module: `vote_tally`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is 0, and `out_class` and `out_scores` are all zero.
- R2: `out_valid` is high exactly two rising clock edges after a rising edge that sampled `in_valid` high, and it is low otherwise.
- R3: The score of class k is the number of set bits in `in_bits[k*NVOTE +: NVOTE]`. It is reported in `out_scores[k*SW +: SW]`, where SW = clog2(NVOTE+1).
- R4: `out_class` is the index of a class whose score is not exceeded by any other class's score.
- R5: When two or more classes share the highest score, `out_class` is the lowest of their indices.
- R6: An input with no votes set yields all scores 0 and `out_class` 0.
- R7: An input with every vote set yields every score equal to NVOTE and `out_class` 0.
- R8: Samples presented on consecutive cycles each produce their own correct result, in order, on consecutive cycles.
- R9: `in_bits` is ignored while `in_valid` is low. When no result is delivered, `out_class` and `out_scores` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_bits` carries a sample this cycle |
| in_bits | input | NCLASS*NVOTE | Voter bits, with class k in bits k*NVOTE to k*NVOTE+NVOTE-1 |
| out_valid | output | 1 | Result available this cycle |
| out_class | output | IW = max(1, clog2(NCLASS)) | Winning class index |
| out_scores | output | NCLASS*SW | Per-class scores, with class k in bits k*SW to k*SW+SW-1 |

## Verification
Two functions can fall in the same cycle: counting the votes of a new sample in the first stage, and choosing the winner of the previous sample in the second stage. The bench provokes this by streaming four different vectors on consecutive cycles. The vectors include a tie and a win by the last class. Each output cycle is compared against a winner and scores computed in the bench from the vector that was presented two cycles earlier. Any mixing of one sample's data into another's result therefore shows up as a mismatch.

// File: rtl/vt_pkg.sv
package vt_pkg;

    // Width of an index over n items, at least one bit
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width needed to hold a count from 0 to n inclusive
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/vt_popcount.sv
module vt_popcount #(
    parameter int W  = 8,
    parameter int SW = 4
) (
    input  logic [W-1:0]  bits,
    output logic [SW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + SW'(bits[i]);
        end
    end
endmodule

// File: rtl/vt_argmax.sv
module vt_argmax #(
    parameter int N  = 4,
    parameter int SW = 4,
    parameter int IW = 2
) (
    input  logic [N*SW-1:0] scores,
    output logic [IW-1:0]   win
);
    logic [SW-1:0] best;

    // Strict greater-than: an equal score never displaces a lower index
    always_comb begin
        best = scores[SW-1:0];
        win  = '0;
        for (int k = 1; k < N; k++) begin
            if (scores[k*SW +: SW] > best) begin
                best = scores[k*SW +: SW];
                win  = IW'(k);
            end
        end
    end
endmodule

// File: rtl/vote_tally.sv
module vote_tally #(
    parameter int NCLASS = 4,
    parameter int NVOTE  = 8,
    localparam int SW    = vt_pkg::count_width(NVOTE),
    localparam int IW    = vt_pkg::idx_width(NCLASS),
    localparam int TOT   = NCLASS * NVOTE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [TOT-1:0]     in_bits,
    output logic               out_valid,
    output logic [IW-1:0]      out_class,
    output logic [NCLASS*SW-1:0] out_scores
);
    logic [NCLASS*SW-1:0] cnt_comb;
    logic [NCLASS*SW-1:0] s1_scores;
    logic                 s1_valid;
    logic [IW-1:0]        win_comb;

    // Stage 1 logic: one population counter per class group
    for (genvar k = 0; k < NCLASS; k++) begin : g_cnt
        vt_popcount #(.W(NVOTE), .SW(SW)) u_cnt (
            .bits  (in_bits[k*NVOTE +: NVOTE]),
            .count (cnt_comb[k*SW +: SW])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_scores <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) s1_scores <= cnt_comb;
        end
    end

    // Stage 2 logic: pick the winner
    vt_argmax #(.N(NCLASS), .SW(SW), .IW(IW)) u_max (
        .scores (s1_scores),
        .win    (win_comb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_class  <= '0;
            out_scores <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_class  <= win_comb;
                out_scores <= s1_scores;
            end
        end
    end

    // Checks on the registered result
    logic [SW-1:0] win_score;
    assign win_score = out_scores[int'(out_class)*SW +: SW];

    a_r2_stage1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(out_class) && $stable(out_scores)));

    for (genvar k = 0; k < NCLASS; k++) begin : g_chk
        a_r3_score_bound: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_scores[k*SW +: SW] <= SW'(NVOTE)));
        a_r4_winner_max: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_scores[k*SW +: SW] <= win_score));
        a_r5_tie_lowest: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && (k < int'(out_class))) |-> (out_scores[k*SW +: SW] < win_score));
    end
endmodule

// File: tb/vote_tally_tb.sv
module vote_tally_tb;
    localparam int NCLASS = 4;
    localparam int NVOTE  = 8;
    localparam int SW     = 4;
    localparam int IW     = 2;
    localparam int TOT    = NCLASS * NVOTE;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [TOT-1:0]     in_bits = '0;
    logic               out_valid;
    logic [IW-1:0]      out_class;
    logic [NCLASS*SW-1:0] out_scores;

    int checks = 0;
    int errors = 0;

    vote_tally #(.NCLASS(NCLASS), .NVOTE(NVOTE)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
        .out_valid(out_valid), .out_class(out_class), .out_scores(out_scores)
    );

    always #5 clk = ~clk;

    function automatic logic [SW-1:0] ref_score(input logic [TOT-1:0] v, input int k);
        logic [SW-1:0] c = '0;
        for (int i = 0; i < NVOTE; i++) c = c + SW'(v[k*NVOTE + i]);
        return c;
    endfunction

    function automatic logic [NCLASS*SW-1:0] ref_all(input logic [TOT-1:0] v);
        logic [NCLASS*SW-1:0] s;
        for (int k = 0; k < NCLASS; k++) s[k*SW +: SW] = ref_score(v, k);
        return s;
    endfunction

    function automatic logic [IW-1:0] ref_class(input logic [TOT-1:0] v);
        int best = -1;
        int idx = 0;
        for (int k = 0; k < NCLASS; k++) begin
            if (int'(ref_score(v, k)) > best) begin
                best = int'(ref_score(v, k));
                idx = k;
            end
        end
        return IW'(idx);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Streams n vectors back to back and checks each result two cycles later
    task automatic run_burst(input string tag, input logic [TOT-1:0] v [4], input int n);
        for (int c = 0; c < n + 2; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check({tag, " R2 valid"}, 32'(out_valid), 32'd1);
                check({tag, " R3 scores"}, 32'(out_scores), 32'(ref_all(v[c-2])));
                check({tag, " R4 class"}, 32'(out_class), 32'(ref_class(v[c-2])));
            end
            if (c < n) begin
                in_valid = 1'b1;
                in_bits  = v[c];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        check("R1 class in reset", 32'(out_class), 32'd0);
        check("R1 scores in reset", 32'(out_scores), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", 32'(out_valid), 32'd0);
    endtask

    task automatic test_single(input string tag, input logic [TOT-1:0] v,
                               input logic [IW-1:0] exp_cls);
        logic [TOT-1:0] arr [4];
        arr[0] = v; arr[1] = '0; arr[2] = '0; arr[3] = '0;
        run_burst(tag, arr, 1);
        check({tag, " class"}, 32'(out_class), 32'(exp_cls));
        @(negedge clk);
        check("R2 valid drops", 32'(out_valid), 32'd0);
    endtask

    task automatic test_back_to_back();
        logic [TOT-1:0] arr [4];
        arr[0] = 32'h00FF0000;
        arr[1] = 32'hFC013F03;
        arr[2] = 32'hFF7F0F01;
        arr[3] = 32'h0103070F;
        run_burst("R8 stream", arr, 4);
    endtask

    task automatic test_ignore_idle();
        logic [IW-1:0]        cls;
        logic [NCLASS*SW-1:0] sc;
        @(negedge clk);
        cls = out_class;
        sc  = out_scores;
        in_valid = 1'b0;
        for (int c = 0; c < 4; c++) begin
            in_bits = 32'hFFFF0000 ^ (32'h01010101 << c);
            @(negedge clk);
            check("R9 valid stays low", 32'(out_valid), 32'd0);
            check("R9 class held", 32'(out_class), 32'(cls));
            check("R9 scores held", 32'(out_scores), 32'(sc));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_single("R6 no votes", 32'h00000000, 2'd0);
        test_single("R7 all votes", 32'hFFFFFFFF, 2'd0);
        test_single("R5 tie 1 and 3", 32'hFC013F03, 2'd1);
        test_single("R4 last class wins", 32'hFF000000, 2'd3);
        test_single("R4 middle class", 32'h0F7F0301, 2'd2);
        test_back_to_back();
        test_ignore_idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule